// File: doc/BRIEF.md
# Standby Clock Gating Sequencer

This block moves a small processor subsystem into a low-power standby state and brings it back. A one-cycle idle request, accepted only while the subsystem runs normally, opens a drain window. During that window the system and peripheral clock enables stay high so the pipeline and any pending operations can finish. When the window closes, both enables drop and the standby flag rises. The enable for the PLL and watchdog clock domains is never lowered.

A wake input ends standby. It is taken either directly or through an input qualifier that requires a run of consecutive high samples of programmable length. Accepting the wake starts a latency counter. Its length depends on where code executes from, which is captured together with the idle request: on-chip RAM or code memory left active gives a short latency, and code memory put to sleep gives a long one. When the count runs out, both clock enables return, the standby flag drops, and a one-cycle resume strobe marks the restart at the instruction after the idle request.

A wake that is accepted while the drain window is still open is remembered. It is acted on as soon as standby is reached.

Top module: `stby_clkgate_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `sys_clk_en`, `periph_clk_en` and `pllwd_clk_en` are 1, and `standby_o` and `resume_o` are 0.
- R2: An `idle_req` sampled high in the running state is followed by exactly FLUSH_CYCLES (default 32, legal range 32 to 45) further clock edges with both clock enables high. On the next edge after that, both enables fall and `standby_o` rises.
- R3: `pllwd_clk_en` is 1 in every cycle, including drain, standby and wake latency.
- R4: `mem_src` is captured on the edge that accepts `idle_req`. The value 2'b00 (RAM) or 2'b01 (code memory active) gives a latency of LAT_FAST = 100 cycles. The value 2'b10 (code memory asleep), and the unused code 2'b11, give LAT_SLOW = 1125 cycles.
- R5: With `qual_en` = 0, a `wake_in` sampled high in standby is accepted on that edge. The clock enables return, `standby_o` falls and `resume_o` is 1 after exactly the latency count of further edges.
- R6: With `qual_en` = 1, a wake is accepted on the edge that samples the `qual_len`-th consecutive high of `wake_in`, which adds `qual_len`-1 cycles to the exit time. A `qual_len` of 0 acts as 1. A run of highs shorter than `qual_len` leaves the block in standby.
- R7: A wake accepted during the drain window is held even if `wake_in` then falls. The latency count starts on the edge after standby is entered.
- R8: `wake_in` has no effect while the block is running: the enables stay high and no resume strobe appears.
- R9: `idle_req` is ignored outside the running state. It neither changes the drain length nor replaces the captured `mem_src`, and it does not leave standby.
- R10: `resume_o` is high for exactly one cycle, in which `sys_clk_en` is 1 and `standby_o` is 0. An `idle_req` sampled in that cycle starts a new drain window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | One-cycle request to enter standby |
| mem_src | input | 2 | Code source: 00 RAM, 01 code memory active, 10/11 code memory asleep |
| wake_in | input | 1 | External wake level |
| qual_en | input | 1 | 1 routes the wake through the consecutive-sample qualifier |
| qual_len | input | 6 | Required number of consecutive high wake samples (0 acts as 1) |
| sys_clk_en | output | 1 | System clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pllwd_clk_en | output | 1 | PLL and watchdog clock enable, always high |
| standby_o | output | 1 | High while clocks are gated (standby and wake latency) |
| resume_o | output | 1 | One-cycle strobe when execution restarts |

## Verification
Two events can meet in one cycle. The first is a wake acceptance landing inside the drain window, up to and including its last edge. The bench provokes it with a single-cycle wake pulse in the middle of the drain, then requires standby to be reached on time and the exit to follow one edge later plus the normal latency, even though the wake has fallen. The second is a new idle request presented in the very cycle the resume strobe is seen. The bench judges that the request is accepted by counting the full drain length again from that cycle. Random rounds mix code sources, qualifier settings and lengths, and compare every drain and exit time with a latency computed by bench functions.

// File: rtl/stby_pkg.sv
package stby_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_FLUSH = 2'd1,
      ST_STBY  = 2'd2,
      ST_WAKE  = 2'd3
   } stby_state_e;

   // Code memory source encodings captured with the idle request
   localparam logic [1:0] SRC_RAM      = 2'b00;
   localparam logic [1:0] SRC_CODE_ON  = 2'b01;
   localparam logic [1:0] SRC_CODE_OFF = 2'b10;

   // Source needs the long wake latency when bit 1 is set (asleep or unused code)
   function automatic logic src_is_slow(input logic [1:0] src);
      return src[1];
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/stby_wake_qual.sv
module stby_wake_qual #(
   parameter int QUAL_W       = 6,
   parameter bit QUAL_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake_in,
   input  logic              qual_en,
   input  logic [QUAL_W-1:0] qual_len,
   output logic              wake_ok
);

   localparam int RUN_W = QUAL_W + 1;

   if (QUAL_W < 1) begin : g_bad_w
      $error("stby_wake_qual: QUAL_W must be at least 1");
   end

   if (QUAL_PRESENT) begin : g_qual
      logic [QUAL_W-1:0] run_cnt;
      logic [RUN_W-1:0]  eff_len;
      logic [RUN_W-1:0]  seen;

      // Count earlier consecutive high samples, saturating at the field maximum
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            run_cnt <= '0;
         end else if (!wake_in) begin
            run_cnt <= '0;
         end else if (run_cnt != {QUAL_W{1'b1}}) begin
            run_cnt <= run_cnt + 1'b1;
         end
      end

      always_comb begin
         eff_len = (qual_len == '0) ? RUN_W'(1) : {1'b0, qual_len};
         seen    = {1'b0, run_cnt} + RUN_W'(1);
         if (qual_en) begin
            wake_ok = wake_in && (seen >= eff_len);
         end else begin
            wake_ok = wake_in;
         end
      end

      // R6: a qualified wake with length above one needs a high sample before it
      assert_qual_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (qual_en && qual_len > QUAL_W'(1) && wake_ok) |-> $past(wake_in));
   end else begin : g_bypass
      logic unused_qual;
      assign unused_qual = ^{qual_en, qual_len, clk, rst_n};
      assign wake_ok     = wake_in;
   end

   // R6: acceptance never happens without the wake input high
   assert_wake_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_ok |-> wake_in);

endmodule

// File: rtl/stby_timer.sv
module stby_timer #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   if (CNT_W < 2) begin : g_bad_w
      $error("stby_timer: CNT_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

   // R2: once run out and not reloaded, the timer stays run out
   assert_timer_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired);

   // R5: a reload to a nonzero value is seen as not run out on the next cycle
   assert_timer_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/stby_seq.sv
module stby_seq
   import stby_pkg::*;
#(
   parameter int FLUSH_CYCLES = 32,
   parameter int LAT_FAST     = 100,
   parameter int LAT_SLOW     = 1125,
   parameter int CNT_W        = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle_req,
   input  logic [1:0]       mem_src,
   input  logic             wake_ok,
   input  logic             tmr_expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             sys_clk_en,
   output logic             periph_clk_en,
   output logic             standby_o,
   output logic             resume_o
);

   localparam logic [CNT_W-1:0] FLUSH_LD = CNT_W'(FLUSH_CYCLES - 1);
   localparam logic [CNT_W-1:0] FAST_LD  = CNT_W'(LAT_FAST - 1);
   localparam logic [CNT_W-1:0] SLOW_LD  = CNT_W'(LAT_SLOW - 1);

   stby_state_e state;
   logic [1:0]  mem_q;
   logic        pend;
   logic        resume_q;
   logic        accept_idle;
   logic        start_wake;

   assign accept_idle = (state == ST_RUN) && idle_req;
   assign start_wake  = (state == ST_STBY) && (wake_ok || pend);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_RUN;
         mem_q    <= SRC_RAM;
         pend     <= 1'b0;
         resume_q <= 1'b0;
      end else begin
         resume_q <= 1'b0;
         unique case (state)
            ST_RUN: begin
               if (idle_req) begin
                  state <= ST_FLUSH;
                  mem_q <= mem_src;
                  pend  <= 1'b0;
               end
            end
            ST_FLUSH: begin
               if (wake_ok) begin
                  pend <= 1'b1;
               end
               if (tmr_expired) begin
                  state <= ST_STBY;
               end
            end
            ST_STBY: begin
               if (wake_ok || pend) begin
                  state <= ST_WAKE;
                  pend  <= 1'b0;
               end
            end
            ST_WAKE: begin
               if (tmr_expired) begin
                  state    <= ST_RUN;
                  resume_q <= 1'b1;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   always_comb begin
      tmr_load = accept_idle || start_wake;
      if (accept_idle) begin
         tmr_val = FLUSH_LD;
      end else if (src_is_slow(mem_q)) begin
         tmr_val = SLOW_LD;
      end else begin
         tmr_val = FAST_LD;
      end
   end

   assign sys_clk_en    = (state == ST_RUN) || (state == ST_FLUSH);
   assign periph_clk_en = (state == ST_RUN) || (state == ST_FLUSH);
   assign standby_o     = (state == ST_STBY) || (state == ST_WAKE);
   assign resume_o      = resume_q;

   // R2: standby is entered only from the drain window
   assert_stby_from_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STBY && $past(state) != ST_STBY) |-> $past(state) == ST_FLUSH);

   // R8: without an idle request the running state holds whatever the wake does
   assert_run_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !idle_req) |=> state == ST_RUN);

   // R9: idle requests in standby do not leave it
   assert_idle_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STBY && idle_req && !wake_ok && !pend) |=> state == ST_STBY);

   // R9: the captured code source only changes in the running state
   assert_src_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_RUN) |=> $stable(mem_q));

   // R10: the resume strobe is a single cycle
   assert_resume_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |=> !resume_o);

   // R10: clocks are back and standby is clear while resuming
   assert_resume_clk_R10: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> (sys_clk_en && periph_clk_en && !standby_o));

   // R7: a latched wake forces the exit right after standby is reached
   assert_pend_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STBY && pend) |=> state == ST_WAKE);

endmodule

// File: rtl/stby_clkgate_ctrl.sv
module stby_clkgate_ctrl
   import stby_pkg::*;
#(
   parameter int FLUSH_CYCLES = 32,
   parameter int LAT_FAST     = 100,
   parameter int LAT_SLOW     = 1125,
   parameter int QUAL_W       = 6,
   parameter bit QUAL_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle_req,
   input  logic [1:0]        mem_src,
   input  logic              wake_in,
   input  logic              qual_en,
   input  logic [QUAL_W-1:0] qual_len,
   output logic              sys_clk_en,
   output logic              periph_clk_en,
   output logic              pllwd_clk_en,
   output logic              standby_o,
   output logic              resume_o
);

   localparam int MAX_LD = max3(FLUSH_CYCLES, LAT_FAST, LAT_SLOW);
   localparam int CNT_W  = $clog2(MAX_LD + 1);

   if (FLUSH_CYCLES < 32 || FLUSH_CYCLES > 45) begin : g_bad_flush
      $error("stby_clkgate_ctrl: FLUSH_CYCLES must lie in 32..45");
   end
   if (LAT_FAST < 1) begin : g_bad_fast
      $error("stby_clkgate_ctrl: LAT_FAST must be at least 1");
   end
   if (LAT_SLOW < LAT_FAST) begin : g_bad_slow
      $error("stby_clkgate_ctrl: LAT_SLOW must not be below LAT_FAST");
   end

   logic             wake_ok;
   logic             tmr_load;
   logic             tmr_expired;
   logic [CNT_W-1:0] tmr_val;

   stby_wake_qual #(
      .QUAL_W       (QUAL_W),
      .QUAL_PRESENT (QUAL_PRESENT)
   ) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .wake_in  (wake_in),
      .qual_en  (qual_en),
      .qual_len (qual_len),
      .wake_ok  (wake_ok)
   );

   stby_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   stby_seq #(
      .FLUSH_CYCLES (FLUSH_CYCLES),
      .LAT_FAST     (LAT_FAST),
      .LAT_SLOW     (LAT_SLOW),
      .CNT_W        (CNT_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .idle_req      (idle_req),
      .mem_src       (mem_src),
      .wake_ok       (wake_ok),
      .tmr_expired   (tmr_expired),
      .tmr_load      (tmr_load),
      .tmr_val       (tmr_val),
      .sys_clk_en    (sys_clk_en),
      .periph_clk_en (periph_clk_en),
      .standby_o     (standby_o),
      .resume_o      (resume_o)
   );

   // PLL and watchdog domains are never gated
   assign pllwd_clk_en = 1'b1;

   // R3: gating the system clock never coincides with gating the PLL/watchdog domain
   assert_pllwd_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_clk_en |-> pllwd_clk_en);

   // R2: standby flag and system clock enable are never both high
   assert_gate_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(standby_o && sys_clk_en));

endmodule

// File: tb/stby_clkgate_ctrl_tb_top.sv
module stby_clkgate_ctrl_tb_top;

   localparam int FLUSH = 32;
   localparam int LFAST = 100;
   localparam int LSLOW = 1125;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       idle_req;
   logic [1:0] mem_src;
   logic       wake_in;
   logic       qual_en;
   logic [5:0] qual_len;
   logic       sys_clk_en, periph_clk_en, pllwd_clk_en, standby_o, resume_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   stby_clkgate_ctrl #(
      .FLUSH_CYCLES (FLUSH),
      .LAT_FAST     (LFAST),
      .LAT_SLOW     (LSLOW)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .idle_req      (idle_req),
      .mem_src       (mem_src),
      .wake_in       (wake_in),
      .qual_en       (qual_en),
      .qual_len      (qual_len),
      .sys_clk_en    (sys_clk_en),
      .periph_clk_en (periph_clk_en),
      .pllwd_clk_en  (pllwd_clk_en),
      .standby_o     (standby_o),
      .resume_o      (resume_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int lat_of(input logic [1:0] m);
      return m[1] ? LSLOW : LFAST;
   endfunction

   // Negedges counted from the wake driving negedge until resume_o is seen
   function automatic int exp_exit(input bit qe, input int n, input logic [1:0] m);
      int q;
      q = (n == 0) ? 1 : n;
      return lat_of(m) + (qe ? q : 1);
   endfunction

   // idle_req was just driven at this negedge; count negedges until gating
   task automatic count_flush(input string req);
      int cnt = 0;
      do begin
         @(negedge clk);
         idle_req = 1'b0;
         cnt++;
      end while (sys_clk_en && cnt < 200);
      chk(cnt == FLUSH + 1, req, cnt, FLUSH + 1);
      chk(standby_o && !periph_clk_en, req, standby_o, 1);
      chk(pllwd_clk_en, "R3", pllwd_clk_en, 1);
   endtask

   task automatic enter(input logic [1:0] m, input string req);
      @(negedge clk);
      idle_req = 1'b1;
      mem_src  = m;
      count_flush(req);
   endtask

   task automatic wake_exit(input bit qe, input int n, input logic [1:0] m,
                            input bit chain, input string req);
      int cnt = 0;
      qual_en  = qe;
      qual_len = 6'(n);
      @(negedge clk);
      wake_in = 1'b1;
      do begin
         @(negedge clk);
         cnt++;
      end while (!resume_o && cnt < 3000);
      chk(cnt == exp_exit(qe, n, m), req, cnt, exp_exit(qe, n, m));
      chk(sys_clk_en && !standby_o, "R10", sys_clk_en, 1);
      wake_in = 1'b0;
      if (chain) begin
         // R10: idle presented in the resume cycle must be accepted
         idle_req = 1'b1;
         mem_src  = 2'b00;
         count_flush("R10 idle in resume cycle");
      end else begin
         @(negedge clk);
         chk(!resume_o, "R10", resume_o, 0);
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      int seed = 32'h5eed_1234;
      int cnt;
      void'($urandom(seed));
      rst_n = 1'b0; idle_req = 1'b0; mem_src = 2'b00;
      wake_in = 1'b0; qual_en = 1'b0; qual_len = 6'd1;
      repeat (3) @(negedge clk);
      chk(sys_clk_en && periph_clk_en && pllwd_clk_en, "R1 enables in reset", sys_clk_en, 1);
      chk(!standby_o && !resume_o, "R1 flags in reset", standby_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sys_clk_en && !standby_o && !resume_o, "R1 after reset", sys_clk_en, 1);

      // R8: wake while running has no effect
      wake_in = 1'b1;
      cnt = 0;
      repeat (6) begin
         @(negedge clk);
         if (!sys_clk_en || resume_o || standby_o) cnt++;
      end
      wake_in = 1'b0;
      chk(cnt == 0, "R8 wake in run ignored", cnt, 0);

      // R2/R4/R5: fast source, unqualified
      enter(2'b00, "R2 flush length");
      wake_exit(1'b0, 1, 2'b00, 1'b0, "R5 R4 RAM exit");

      // R4: slow source
      enter(2'b10, "R2 flush length slow");
      wake_exit(1'b0, 1, 2'b10, 1'b0, "R4 code asleep exit");

      // R4: code memory active and unused code
      enter(2'b01, "R2 flush length");
      wake_exit(1'b0, 1, 2'b01, 1'b0, "R4 code active exit");
      enter(2'b11, "R2 flush length");
      wake_exit(1'b0, 1, 2'b11, 1'b0, "R4 unused code exit");

      // R6: short pulse rejected, then qualified exit
      enter(2'b00, "R2 flush length");
      qual_en = 1'b1; qual_len = 6'd5;
      @(negedge clk); wake_in = 1'b1;
      repeat (4) @(negedge clk);
      wake_in = 1'b0;
      repeat (20) @(negedge clk);
      chk(standby_o && !resume_o, "R6 short run ignored", standby_o, 1);
      wake_exit(1'b1, 5, 2'b00, 1'b0, "R6 qualified exit");
      enter(2'b00, "R2 flush length");
      wake_exit(1'b1, 0, 2'b00, 1'b0, "R6 length zero acts as one");
      enter(2'b10, "R2 flush length");
      wake_exit(1'b1, 63, 2'b10, 1'b0, "R6 maximum length");

      // R9: idle with a different source during drain, and in standby
      @(negedge clk);
      idle_req = 1'b1; mem_src = 2'b00;
      cnt = 0;
      do begin
         @(negedge clk);
         idle_req = (cnt == 5);
         if (cnt == 5) mem_src = 2'b10;
         cnt++;
      end while (sys_clk_en && cnt < 200);
      chk(cnt == FLUSH + 1, "R9 idle in drain ignored", cnt, FLUSH + 1);
      idle_req = 1'b1;
      @(negedge clk); idle_req = 1'b0;
      repeat (3) @(negedge clk);
      chk(standby_o, "R9 idle in standby ignored", standby_o, 1);
      wake_exit(1'b0, 1, 2'b00, 1'b0, "R9 source not replaced");

      // R7: single-cycle wake during drain is held
      qual_en = 1'b0;
      @(negedge clk);
      idle_req = 1'b1; mem_src = 2'b00;
      cnt = 0;
      do begin
         @(negedge clk);
         idle_req = 1'b0;
         wake_in  = (cnt == 10);
         cnt++;
      end while (sys_clk_en && cnt < 200);
      wake_in = 1'b0;
      chk(cnt == FLUSH + 1, "R7 drain not shortened", cnt, FLUSH + 1);
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!resume_o && cnt < 3000);
      chk(cnt == LFAST + 1, "R7 latched wake exit", cnt, LFAST + 1);

      // R10: idle in the resume cycle chains into a new drain
      @(negedge clk);
      enter(2'b01, "R2 flush length");
      wake_exit(1'b0, 1, 2'b01, 1'b1, "R5 exit before chain");
      wake_exit(1'b0, 1, 2'b00, 1'b0, "R5 exit after chain");

      // Random rounds
      for (int i = 0; i < 14; i++) begin
         logic [1:0] m;
         bit qe;
         int n;
         m  = 2'($urandom_range(0, 3));
         qe = 1'($urandom_range(0, 1));
         n  = $urandom_range(0, 63);
         enter(m, "R2 random flush");
         repeat ($urandom_range(0, 7)) @(negedge clk);
         wake_exit(qe, n, m, 1'b0, "R4 R5 R6 random exit");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule